// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block moves 32-bit words from a data source that sits at one fixed local address, such as a receive FIFO, into host memory. It does not take one transfer programmed by register. It reads a chain of descriptors from memory, and each descriptor gives a host buffer, the local address and a byte count. Software builds the descriptors as a ring, with the last one linking back to the first. The engine therefore keeps filling the same buffers in turn until software turns it off.

Software uses two writable registers. The first is a pointer to the first descriptor. The second is a command byte that carries the enable, start and interrupt-acknowledge bits. A descriptor's link word can ask for an interrupt when that descriptor completes; the interrupt stays pending until software acknowledges it. Data moves only while the source says it holds a word, and only while the memory write port accepts it. The current host address is visible at all times, so software can tell how far the ring has been filled.

Top module: `ring_dma`

## Requirements
- R1: After reset the engine is idle. No descriptor read and no data write is requested, the interrupt is low, and the current host address reads zero.
- R2: A write to the command byte (reg_sel=1) with bit 0 (enable) and bit 1 (start) both set, made while the engine is idle, starts a descriptor fetch at the pointer register (reg_sel=0). A start written without enable leaves the engine idle.
- R3: A descriptor is four 32-bit words at offsets 0, 4, 8 and 12. In that order they are the host start address, the local address, the byte count and the link word. They are fetched one word at a time through the read port.
- R4: Data words are written to consecutive host addresses, rising by 4 from the host start address, in the order the source supplies them. A word moves in each cycle in which src_ready and mwr_ready are both high. cur_addr_o always shows the address of the next word.
- R5: While src_ready is low, no word is written, no word is popped and the current host address does not change.
- R6: While a descriptor is being worked, local_addr_o holds that descriptor's local address and does not change.
- R7: The low two bits of the byte count are ignored. A count above MAX_XFER_BYTES is treated as MAX_XFER_BYTES.
- R8: A descriptor whose byte count is below 4 produces no data write. The engine goes straight on to fetch the next descriptor.
- R9: When the last word of a descriptor has moved, the next descriptor is fetched from the link word with its low four bits cleared. A link back to the first descriptor makes the ring repeat without end.
- R10: The interrupt goes high after the last word of a descriptor whose link word has bit 1 set. It stays high until it is acknowledged. A descriptor with link bit 1 clear does not raise it.
- R11: A command write with bit 3 set clears a pending interrupt. The enable bit of the same write takes effect, so a write of enable plus acknowledge leaves the engine running. An interrupt raised in the same cycle as the acknowledge wins.
- R12: A command write with bit 0 clear returns the engine to idle. No further word is popped or written after that, and the current host address keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the descriptor pointer, 1 selects the command byte |
| reg_wdata | input | WORD_W | Register write data |
| busy_o | output | 1 | Engine is not idle |
| irq_o | output | 1 | Interrupt pending |
| cur_addr_o | output | WORD_W | Host address of the next data word |
| local_addr_o | output | WORD_W | Fixed local source address of the current descriptor |
| mrd_req | output | 1 | Descriptor read request |
| mrd_addr | output | WORD_W | Descriptor read address |
| mrd_valid | input | 1 | Read data valid; completes the request |
| mrd_data | input | WORD_W | Read data |
| mwr_valid | output | 1 | Data write valid |
| mwr_addr | output | WORD_W | Data write host address |
| mwr_data | output | WORD_W | Data write word |
| mwr_ready | input | 1 | Write port accepts the word |
| src_ready | input | 1 | Source holds a word (demand request) |
| src_data | input | WORD_W | Source word |
| src_pop | output | 1 | Source word taken this cycle |

## Verification
A register write takes effect at the clock edge that captures it. A start begins the first descriptor read one cycle after that edge. Each descriptor then takes four read cycles, and the data stage is loaded in the cycle of the fourth read. A word is written in the same cycle in which src_ready and mwr_ready are both high, and cur_addr_o has advanced by the next cycle. A disable reaches idle one cycle after the write. The scoreboard samples each write just after the falling edge, so the word it sees is the one that is taken at the next rising edge. The bench withdraws src_ready once the queue of expected words is empty, and it waits a margin of several cycles before it checks the registered outputs, which allows the four fetch cycles of the next descriptor.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

    // command byte bit positions
    localparam int CMD_EN_BIT  = 0;
    localparam int CMD_GO_BIT  = 1;
    localparam int CMD_ACK_BIT = 3;

    // link word flag: interrupt when this descriptor completes
    localparam int LNK_IRQ_BIT = 1;

    // descriptor word indices
    localparam logic [1:0] DW_HOST  = 2'd0;
    localparam logic [1:0] DW_LOCAL = 2'd1;
    localparam logic [1:0] DW_SIZE  = 2'd2;
    localparam logic [1:0] DW_LINK  = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_MOVE  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ring_dma_ctrl.sv
module ring_dma_ctrl
    import ring_dma_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              eod_irq_i,
    output logic [WORD_W-1:0] ptr_o,
    output logic              en_o,
    output logic              start_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [WORD_W-1:0] ptr;
        logic              en;
        logic              start;
        logic              irq;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (reg_wr && !reg_sel) begin
            s_d.ptr = reg_wdata;
        end
        if (reg_wr && reg_sel) begin
            s_d.en    = reg_wdata[CMD_EN_BIT];
            s_d.start = reg_wdata[CMD_EN_BIT] && reg_wdata[CMD_GO_BIT];
            if (reg_wdata[CMD_ACK_BIT]) begin
                s_d.irq = 1'b0;
            end
        end
        if (eod_irq_i) begin
            s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr_o   = s_q.ptr;
    assign en_o    = s_q.en;
    assign start_o = s_q.start;
    assign irq_o   = s_q.irq;

    // R11
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata[CMD_ACK_BIT] && !eod_irq_i) |=> !irq_o);

    // R10
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eod_irq_i |=> irq_o);

    // R11
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> (en_o == $past(reg_wdata[CMD_EN_BIT])));

endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
    import ring_dma_pkg::*;
#(
    parameter int WORD_W         = 32,
    parameter int MAX_XFER_BYTES = 65536,
    parameter int CNT_W          = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] ptr_i,
    output logic              mrd_req_o,
    output logic [WORD_W-1:0] mrd_addr_o,
    input  logic              mrd_valid_i,
    input  logic [WORD_W-1:0] mrd_data_i,
    output logic              load_o,
    output logic [WORD_W-1:0] host_o,
    output logic [WORD_W-1:0] local_o,
    output logic [CNT_W-1:0]  words_o,
    input  logic              done_i,
    output logic              eod_irq_o,
    output logic              busy_o
);

    localparam int MAX_WORDS = MAX_XFER_BYTES / 4;

    typedef struct packed {
        seq_state_e        st;
        logic [1:0]        idx;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] host;
        logic [WORD_W-1:0] loc;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] next;
        logic              lnk_irq;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] words;

    function automatic logic [WORD_W-1:0] align16(input logic [WORD_W-1:0] a);
        return {a[WORD_W-1:4], 4'b0000};
    endfunction

    function automatic logic [CNT_W-1:0] clamp_words(input logic [WORD_W-1:0] sz);
        if (sz >= WORD_W'(MAX_XFER_BYTES)) begin
            return CNT_W'(MAX_WORDS);
        end
        return CNT_W'(sz >> 2);
    endfunction

    assign words = clamp_words(s_q.size);

    always_comb begin
        s_d        = s_q;
        load_o     = 1'b0;
        eod_irq_o  = 1'b0;
        mrd_req_o  = 1'b0;
        mrd_addr_o = s_q.base | WORD_W'({s_q.idx, 2'b00});
        case (s_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    s_d.st   = SQ_FETCH;
                    s_d.base = align16(ptr_i);
                    s_d.idx  = DW_HOST;
                end
            end
            SQ_FETCH: begin
                mrd_req_o = en_i;
                if (mrd_valid_i) begin
                    s_d.idx = s_q.idx + 2'd1;
                    case (s_q.idx)
                        DW_HOST:  s_d.host = mrd_data_i;
                        DW_LOCAL: s_d.loc  = mrd_data_i;
                        DW_SIZE:  s_d.size = mrd_data_i;
                        default: begin
                            if (words == '0) begin
                                s_d.base = align16(mrd_data_i);
                            end else begin
                                load_o      = 1'b1;
                                s_d.next    = align16(mrd_data_i);
                                s_d.lnk_irq = mrd_data_i[LNK_IRQ_BIT];
                                s_d.st      = SQ_MOVE;
                            end
                        end
                    endcase
                end
            end
            SQ_MOVE: begin
                if (done_i) begin
                    eod_irq_o = s_q.lnk_irq;
                    s_d.base  = s_q.next;
                    s_d.idx   = DW_HOST;
                    s_d.st    = SQ_FETCH;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
        if (!en_i) begin
            s_d.st    = SQ_IDLE;
            load_o    = 1'b0;
            eod_irq_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign host_o  = s_q.host;
    assign local_o = s_q.loc;
    assign words_o = words;
    assign busy_o  = (s_q.st != SQ_IDLE);

    // R9
    chain_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && en_i && busy_o) |=> (mrd_req_o || !en_i) && (mrd_addr_o[3:0] == 4'h0));

    // R12
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !busy_o);

    // R3
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req_o |-> (mrd_addr_o[1:0] == 2'b00));

endmodule

// File: rtl/ring_dma_mover.sv
module ring_dma_mover #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] host_i,
    input  logic [WORD_W-1:0] local_i,
    input  logic [CNT_W-1:0]  words_i,
    input  logic              src_ready_i,
    input  logic [WORD_W-1:0] src_data_i,
    output logic              src_pop_o,
    output logic              mwr_valid_o,
    output logic [WORD_W-1:0] mwr_addr_o,
    output logic [WORD_W-1:0] mwr_data_o,
    input  logic              mwr_ready_i,
    output logic              done_o,
    output logic [WORD_W-1:0] cur_addr_o,
    output logic [WORD_W-1:0] local_addr_o
);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] loc;
    } mov_t;

    mov_t s_d, s_q;
    logic move;

    always_comb begin
        s_d         = s_q;
        mwr_valid_o = s_q.active && src_ready_i;
        move        = mwr_valid_o && mwr_ready_i;
        done_o      = move && (s_q.cnt == CNT_W'(1));
        if (move) begin
            s_d.addr = s_q.addr + WORD_W'(4);
            s_d.cnt  = s_q.cnt - CNT_W'(1);
            if (done_o) begin
                s_d.active = 1'b0;
            end
        end
        if (load_i) begin
            s_d.active = 1'b1;
            s_d.cnt    = words_i;
            s_d.addr   = host_i;
            s_d.loc    = local_i;
        end
        if (!en_i) begin
            s_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign src_pop_o    = move;
    assign mwr_addr_o   = s_q.addr;
    assign mwr_data_o   = src_data_i;
    assign cur_addr_o   = s_q.addr;
    assign local_addr_o = s_q.loc;

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_valid_o && mwr_ready_i && !load_i) |=> (cur_addr_o == $past(cur_addr_o) + WORD_W'(4)));

    // R5
    demand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ready_i && !load_i) |=> $stable(cur_addr_o));

    // R6
    local_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !load_i) |=> $stable(local_addr_o));

endmodule

// File: rtl/ring_dma.sv
module ring_dma #(
    parameter int WORD_W         = 32,
    parameter int MAX_XFER_BYTES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              busy_o,
    output logic              irq_o,
    output logic [WORD_W-1:0] cur_addr_o,
    output logic [WORD_W-1:0] local_addr_o,
    output logic              mrd_req,
    output logic [WORD_W-1:0] mrd_addr,
    input  logic              mrd_valid,
    input  logic [WORD_W-1:0] mrd_data,
    output logic              mwr_valid,
    output logic [WORD_W-1:0] mwr_addr,
    output logic [WORD_W-1:0] mwr_data,
    input  logic              mwr_ready,
    input  logic              src_ready,
    input  logic [WORD_W-1:0] src_data,
    output logic              src_pop
);

    localparam int MAX_WORDS = MAX_XFER_BYTES / 4;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);

    logic [WORD_W-1:0] ptr;
    logic              en;
    logic              start;
    logic              eod_irq;
    logic              load;
    logic [WORD_W-1:0] host;
    logic [WORD_W-1:0] loc;
    logic [CNT_W-1:0]  words;
    logic              done;

    ring_dma_ctrl #(
        .WORD_W(WORD_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .eod_irq_i(eod_irq),
        .ptr_o    (ptr),
        .en_o     (en),
        .start_o  (start),
        .irq_o    (irq_o)
    );

    ring_dma_seq #(
        .WORD_W        (WORD_W),
        .MAX_XFER_BYTES(MAX_XFER_BYTES),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .start_i    (start),
        .ptr_i      (ptr),
        .mrd_req_o  (mrd_req),
        .mrd_addr_o (mrd_addr),
        .mrd_valid_i(mrd_valid),
        .mrd_data_i (mrd_data),
        .load_o     (load),
        .host_o     (host),
        .local_o    (loc),
        .words_o    (words),
        .done_i     (done),
        .eod_irq_o  (eod_irq),
        .busy_o     (busy_o)
    );

    ring_dma_mover #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) u_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .load_i      (load),
        .host_i      (host),
        .local_i     (loc),
        .words_i     (words),
        .src_ready_i (src_ready),
        .src_data_i  (src_data),
        .src_pop_o   (src_pop),
        .mwr_valid_o (mwr_valid),
        .mwr_addr_o  (mwr_addr),
        .mwr_data_o  (mwr_data),
        .mwr_ready_i (mwr_ready),
        .done_o      (done),
        .cur_addr_o  (cur_addr_o),
        .local_addr_o(local_addr_o)
    );

endmodule

// File: tb/sim_ring_dma.sv
module sim_ring_dma;

    localparam int W    = 32;
    localparam int MAXB = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [W-1:0]  reg_wdata = '0;
    logic          busy_o, irq_o;
    logic [W-1:0]  cur_addr_o, local_addr_o;
    logic          mrd_req, mrd_valid;
    logic [W-1:0]  mrd_addr, mrd_data;
    logic          mwr_valid;
    logic [W-1:0]  mwr_addr, mwr_data;
    logic          mwr_ready = 1'b1;
    logic          src_ready = 1'b0;
    logic [W-1:0]  src_data = 32'h100;
    logic          src_pop;

    logic [W-1:0]  dmem [0:15];
    assign mrd_valid = mrd_req;
    assign mrd_data  = dmem[mrd_addr[5:2]];

    always @(posedge clk) if (src_pop) src_data <= src_data + 1;

    ring_dma #(.WORD_W(W), .MAX_XFER_BYTES(MAXB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy_o(busy_o), .irq_o(irq_o),
        .cur_addr_o(cur_addr_o), .local_addr_o(local_addr_o),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_valid(mrd_valid),
        .mrd_data(mrd_data), .mwr_valid(mwr_valid), .mwr_addr(mwr_addr),
        .mwr_data(mwr_data), .mwr_ready(mwr_ready), .src_ready(src_ready),
        .src_data(src_data), .src_pop(src_pop)
    );

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] d;
        logic [W-1:0] l;
    } item_t;

    item_t        exp_q[$];
    logic [W-1:0] exp_data = 32'h100;
    int           n_chk = 0;
    int           n_bad = 0;
    int           skip_hits = 0;
    int           src_mode = 0;   // 0 off, 1 while words expected, 2 always on
    bit           bp = 1'b0;
    bit           tog = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic sel, input logic [W-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push(input logic [W-1:0] host, input logic [W-1:0] loc, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{host + W'(4 * i), exp_data, loc});
            exp_data = exp_data + 1;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: drives the demand and backpressure lines, scores every write
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            tog = ~tog;
            src_ready = (src_mode == 2) || (src_mode == 1 && exp_q.size() != 0);
            mwr_ready = !bp || tog;
            #1;
            if (mwr_valid && mwr_ready) begin
                if (mwr_addr[15:12] == 4'h2) skip_hits++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 R5 R12 unexpected write", mwr_addr, '0);
                end else begin
                    it = exp_q.pop_front();
                    chk(mwr_addr == it.a, "R4 host address (R3 layout)", mwr_addr, it.a);
                    chk(mwr_data == it.d, "R4 data order", mwr_data, it.d);
                    chk(local_addr_o == it.l, "R6 local address", local_addr_o, it.l);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R4 actual=0x0 expected=0x1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // D0: host 0x1000, 8 bytes, link to D1 with irq flag
        dmem[0]  = 32'h1000; dmem[1]  = 32'hA0; dmem[2]  = 32'd8;   dmem[3]  = 32'h10 | 32'hB;
        // D1: zero-length, skipped
        dmem[4]  = 32'h2000; dmem[5]  = 32'hA4; dmem[6]  = 32'd0;   dmem[7]  = 32'h20 | 32'h9;
        // D2: 10 bytes -> 2 words, links back to D0
        dmem[8]  = 32'h3000; dmem[9]  = 32'hA8; dmem[10] = 32'd10;  dmem[11] = 32'h00 | 32'h9;
        // D3: 100 bytes clamps to MAXB, self ring, no irq flag
        dmem[12] = 32'h4000; dmem[13] = 32'hB0; dmem[14] = 32'd100; dmem[15] = 32'h30 | 32'h9;

        step(3);
        @(negedge clk); rst_n = 1'b1;
        step(1);
        // R1
        chk(!busy_o, "R1 busy", {31'b0, busy_o}, 0);
        chk(!irq_o, "R1 irq", {31'b0, irq_o}, 0);
        chk(!mrd_req && !mwr_valid, "R1 requests", {30'b0, mrd_req, mwr_valid}, 0);
        chk(cur_addr_o == 0, "R1 cur addr", cur_addr_o, 0);

        // ring D0 -> D1(skip, R8) -> D2 -> D0, three laps
        for (int lap = 0; lap < 3; lap++) begin
            push(32'h1000, 32'hA0, 2);
            push(32'h3000, 32'hA8, 2);   // R7: 10 bytes gives 2 words
        end
        wr(1'b0, 32'h0000_000B);          // R2 low pointer bits masked
        wr(1'b1, 32'h03);
        src_mode = 1;
        drain();
        step(8);
        chk(skip_hits == 0, "R8 zero-length descriptor wrote", skip_hits, 0);
        chk(irq_o, "R10 irq after flagged descriptor", {31'b0, irq_o}, 1);
        chk(cur_addr_o == 32'h1000, "R9 ring wrap to first buffer", cur_addr_o, 32'h1000);
        chk(busy_o, "R9 still running", {31'b0, busy_o}, 1);

        wr(1'b1, 32'h09);
        step(1);
        chk(!irq_o, "R11 acknowledge clears irq", {31'b0, irq_o}, 0);
        chk(busy_o, "R11 enable kept", {31'b0, busy_o}, 1);

        wr(1'b1, 32'h00);
        step(2);
        chk(!busy_o, "R12 disable to idle", {31'b0, busy_o}, 0);
        chk(cur_addr_o == 32'h1000, "R12 address held", cur_addr_o, 32'h1000);

        // start without enable is ignored
        src_mode = 0;
        wr(1'b0, 32'h30);
        wr(1'b1, 32'h02);
        step(4);
        chk(!busy_o && !mrd_req, "R2 start without enable", {30'b0, busy_o, mrd_req}, 0);

        wr(1'b1, 32'h03);
        step(10);
        chk(busy_o, "R2 started", {31'b0, busy_o}, 1);
        chk(cur_addr_o == 32'h4000, "R5 no move without demand", cur_addr_o, 32'h4000);
        chk(!mwr_valid && !src_pop, "R5 no write or pop", {30'b0, mwr_valid, src_pop}, 0);
        chk(local_addr_o == 32'hB0, "R6 local address loaded", local_addr_o, 32'hB0);

        bp = 1'b1;
        push(32'h4000, 32'hB0, MAXB / 4);  // R7 clamp to MAXB bytes
        src_mode = 1;
        drain();
        step(8);
        chk(!irq_o, "R10 no irq without flag", {31'b0, irq_o}, 0);
        chk(cur_addr_o == 32'h4000, "R7 R9 clamp then self ring", cur_addr_o, 32'h4000);

        push(32'h4000, 32'hB0, 3);
        drain();
        step(3);
        chk(cur_addr_o == 32'h400C, "R4 cur addr mid buffer", cur_addr_o, 32'h400C);

        src_mode = 0;
        wr(1'b1, 32'h00);
        step(2);
        chk(!busy_o, "R12 idle after disable", {31'b0, busy_o}, 0);
        src_mode = 2;
        step(6);
        chk(cur_addr_o == 32'h400C, "R12 no movement after disable", cur_addr_o, 32'h400C);
        chk(!src_pop, "R12 no pop after disable", {31'b0, src_pop}, 0);
        src_mode = 0;
        step(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule